// File: doc/BRIEF.md
# Scaled 64-bit System Counter

This block keeps a 64-bit time base that advances on an input tick pulse. A 32-bit register port with a single-cycle write and a combinational read lets software start and stop counting, preload the count and pick the step size. Timers elsewhere on the chip compare against the full 64-bit value, which is driven on an output.

There are two counting modes. In whole-unit mode each tick adds one. In scaled mode each tick adds an unsigned fixed-point factor with 24 fractional bits. A 24-bit accumulator holds the fractional remainder between ticks, so slow rates such as 1/16 or 1/3 lose no time. Factors above one make the count advance by several units per tick.

Top module: `scaled_sys_counter`

## Requirements
- R1: After reset the count is 0, the control register reads 0, status bit 0 reads 1 and the scale register reads 0x01000000.
- R2: While control bit 0 (enable) is 0, ticks leave the count unchanged.
- R3: With enable set and control bit 2 (scaled mode) clear, each cycle with the tick input high adds exactly 1 to the count. Cycles without a tick leave the count unchanged.
- R4: In scaled mode each tick adds the 32-bit scale value (8 integer bits and 24 fractional bits, at address 0x10) to the fractional accumulator. The integer part of the sum goes into the count. A scale of 0x00100000 therefore gives one count per 16 ticks.
- R5: The fractional remainder carries from tick to tick, and factors above 1.0 add several units per tick. For example, 0x01800000 gives 15 counts for 10 ticks and 0x00555555 gives 2 counts for 9 ticks.
- R6: A write to address 0x8 replaces count bits 31:0 and a write to address 0xC replaces count bits 63:32. The other half keeps its value.
- R7: A count write in the same cycle as a tick wins: the count takes the written value and that tick is dropped.
- R8: A write to the count halves or to the scale register clears the fractional accumulator.
- R9: A carry out of count bit 31 reaches bits 63:32 on the same tick.
- R10: Address 0x4 reads back 1 in bit 0 when enable is clear and 0 when it is set. Address 0x0 reads back only bits 0 and 2, and all other bits read 0.
- R11: Reads of unmapped addresses return 0. Writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Count tick, one per high cycle |
| bus_addr_i | input | 5 | Register byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| count_o | output | 64 | Current 64-bit count |

## Verification
A tick and a software write to the count can arrive in the same cycle. So can a tick and a scale write that clears the accumulator. The bench provokes the first by raising the tick in the same cycle as a low-half write, then checks that the count equals the written value with nothing added. It provokes the second by rewriting the scale between two half-unit ticks, then checks that no whole unit appears until a further tick. A third case drives a tick at the moment the low half is all ones and checks that the high half moves on that same tick.

// File: rtl/scnt_pkg.sv
// Package: shared widths, register addresses and control bit positions
// for the scaled system counter. Assumes a 32-bit register port.
package scnt_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 5;
    localparam int CNT_W  = 64;
    localparam int FRAC_W = 24;
    localparam int INC_W  = BUS_W - FRAC_W + 1;

    localparam logic [ADDR_W-1:0] A_CTRL   = 5'h00;
    localparam logic [ADDR_W-1:0] A_STATUS = 5'h04;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 5'h08;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 5'h0C;
    localparam logic [ADDR_W-1:0] A_SCALE  = 5'h10;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_SCL_BIT = 2;

    localparam logic [BUS_W-1:0] SCALE_RESET = 32'h0100_0000;
endpackage

// File: rtl/scnt_regs.sv
// Register file: holds the control and scale registers, decodes
// write strobes for the count halves and builds the read data.
// Assumes a single-cycle write and a combinational read.
module scnt_regs
    import scnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              en_o,
    output logic              scaled_o,
    output logic [BUS_W-1:0]  scale_o,
    output logic              scale_wr_o,
    output logic [1:0]        cnt_wr_o,
    output logic [BUS_W-1:0]  rdata_o
);
    logic en_q, scaled_q;
    logic [BUS_W-1:0] scale_q;

    // Write decode for the count halves and the scale register
    always_comb begin
        cnt_wr_o[0] = we_i && (addr_i == A_CNT_LO);
        cnt_wr_o[1] = we_i && (addr_i == A_CNT_HI);
        scale_wr_o  = we_i && (addr_i == A_SCALE);
    end

    // Control and scale register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            scaled_q <= 1'b0;
            scale_q  <= SCALE_RESET;
        end else begin
            if (we_i && addr_i == A_CTRL) begin
                en_q     <= wdata_i[CTRL_EN_BIT];
                scaled_q <= wdata_i[CTRL_SCL_BIT];
            end
            if (scale_wr_o) scale_q <= wdata_i;
        end
    end

    // Read data multiplexer
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_CTRL: begin
                rdata_o[CTRL_EN_BIT]  = en_q;
                rdata_o[CTRL_SCL_BIT] = scaled_q;
            end
            A_STATUS: rdata_o[0] = ~en_q;
            A_CNT_LO: rdata_o = count_i[BUS_W-1:0];
            A_CNT_HI: rdata_o = count_i[CNT_W-1:BUS_W];
            A_SCALE:  rdata_o = scale_q;
            default:  rdata_o = '0;
        endcase
    end

    assign en_o     = en_q;
    assign scaled_o = scaled_q;
    assign scale_o  = scale_q;
endmodule

// File: rtl/scnt_frac.sv
// Step generator: in scaled mode it adds the scale factor to a 24-bit
// fractional accumulator and hands out the integer part. In whole-unit
// mode it hands out 1. Assumes clear_i has priority over stepping.
module scnt_frac
    import scnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scaled_i,
    input  logic              step_i,
    input  logic              clear_i,
    input  logic [BUS_W-1:0]  scale_i,
    output logic [INC_W-1:0]  inc_o,
    output logic [FRAC_W-1:0] frac_o
);
    logic [FRAC_W-1:0] frac_q;
    logic [BUS_W:0]    sum;

    // Sum of remainder and scale factor
    always_comb begin
        sum = {{(BUS_W+1-FRAC_W){1'b0}}, frac_q} + {1'b0, scale_i};
        inc_o = scaled_i ? sum[BUS_W:FRAC_W] : INC_W'(1);
    end

    // Fractional remainder register
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) frac_q <= '0;
        else if (step_i && scaled_i) frac_q <= sum[FRAC_W-1:0];
    end

    assign frac_o = frac_q;
endmodule

// File: rtl/scnt_count.sv
// Count register: 64 bits kept as two 32-bit halves. A half write
// replaces that half and blocks the advance for the cycle. Otherwise
// the count adds the step, with the carry crossing halves at once.
module scnt_count
    import scnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic [INC_W-1:0] inc_i,
    input  logic [1:0]       wr_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic [CNT_W-1:0] count_o
);
    localparam int HALVES = CNT_W / BUS_W;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] sum;
    logic             any_wr;

    // Full-width sum so the low-half carry reaches the high half
    always_comb begin
        sum    = count_q + {{(CNT_W-INC_W){1'b0}}, inc_i};
        any_wr = |wr_i;
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        // Per-half update: a write wins, then the advance
        always_ff @(posedge clk) begin
            if (!rst_n) count_q[h*BUS_W +: BUS_W] <= '0;
            else if (wr_i[h]) count_q[h*BUS_W +: BUS_W] <= wdata_i;
            else if (adv_i && !any_wr) count_q[h*BUS_W +: BUS_W] <= sum[h*BUS_W +: BUS_W];
        end
    end

    assign count_o = count_q;
endmodule

// File: rtl/scaled_sys_counter.sv
// Top: scaled 64-bit system counter with a 32-bit register port.
// Assumes tick_i is synchronous to clk and lasts one cycle per tick.
module scaled_sys_counter
    import scnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    output logic [CNT_W-1:0]  count_o
);
    logic              ctrl_en, ctrl_scaled, scale_wr, step;
    logic [1:0]        cnt_wr;
    logic [BUS_W-1:0]  scale_val;
    logic [INC_W-1:0]  inc;
    logic [FRAC_W-1:0] frac_val;

    assign step = tick_i && ctrl_en;

    scnt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr_i), .we_i(bus_we_i),
        .wdata_i(bus_wdata_i), .count_i(count_o), .en_o(ctrl_en),
        .scaled_o(ctrl_scaled), .scale_o(scale_val), .scale_wr_o(scale_wr),
        .cnt_wr_o(cnt_wr), .rdata_o(bus_rdata_o)
    );

    scnt_frac u_frac (
        .clk(clk), .rst_n(rst_n), .scaled_i(ctrl_scaled), .step_i(step),
        .clear_i(scale_wr || (|cnt_wr)), .scale_i(scale_val),
        .inc_o(inc), .frac_o(frac_val)
    );

    scnt_count u_count (
        .clk(clk), .rst_n(rst_n), .adv_i(step), .inc_i(inc),
        .wr_i(cnt_wr), .wdata_i(bus_wdata_i), .count_o(count_o)
    );
endmodule

// File: rtl/scnt_checker.sv
// Checker: temporal properties of the scaled counter, bound to the top.
module scnt_checker
    import scnt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_we_i,
    input logic [BUS_W-1:0]  bus_wdata_i,
    input logic [BUS_W-1:0]  bus_rdata_o,
    input logic [CNT_W-1:0]  count_o,
    input logic              ctrl_en,
    input logic              ctrl_scaled,
    input logic [FRAC_W-1:0] frac_val
);
    assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !bus_we_i) |=> $stable(count_o));

    assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !bus_we_i) |=> $stable(count_o));

    assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && !ctrl_scaled && tick_i && !bus_we_i) |=> count_o == $past(count_o) + 64'd1);

    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == A_CNT_LO) |=> count_o[31:0] == $past(bus_wdata_i));

    assert_frac_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == A_SCALE) |=> frac_val == '0);

    assert_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == A_STATUS) |-> bus_rdata_o == {31'b0, !ctrl_en});

    assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == 5'h14) |-> bus_rdata_o == '0);
endmodule

bind scaled_sys_counter scnt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_addr_i(bus_addr_i),
    .bus_we_i(bus_we_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .count_o(count_o), .ctrl_en(ctrl_en), .ctrl_scaled(ctrl_scaled),
    .frac_val(frac_val)
);

// File: tb/scaled_sys_counter_bench.sv
module scaled_sys_counter_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 6;
    localparam logic [31:0] V_SCALE [NVEC] = '{32'h0100_0000, 32'h0010_0000,
        32'h0180_0000, 32'h0080_0000, 32'h0055_5555, 32'h1000_0000};
    localparam int V_TICKS [NVEC] = '{16, 160, 10, 7, 9, 5};
    localparam logic [31:0] V_EXP [NVEC] = '{32'd16, 32'd10, 32'd15, 32'd3, 32'd2, 32'd80};

    logic        clk = 0, rst_n = 0, tick = 0, we = 0;
    logic [4:0]  addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic [63:0] count;
    int total = 0, bad = 0;
    logic [31:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    scaled_sys_counter u_scaled_sys_counter (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_addr_i(addr),
        .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .count_o(count)
    );

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1;
        @(negedge clk); we = 0;
    endtask

    task automatic rdreg(logic [4:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1;
        end
        @(negedge clk); tick = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 count", count, 64'd0);
        rdreg(5'h00, rd); chk("R1 ctrl", {32'd0, rd}, 64'd0);
        rdreg(5'h04, rd); chk("R1 status", {32'd0, rd}, 64'd1);
        rdreg(5'h10, rd); chk("R1 scale", {32'd0, rd}, 64'h0100_0000);
        // R2 disabled ticks ignored
        ticks(20);
        chk("R2 halted", count, 64'd0);
        // R3 unscaled counting, R10 status/control readback
        wr(5'h00, 32'hFFFF_FFFB);
        rdreg(5'h00, rd); chk("R10 ctrl bits", {32'd0, rd}, 64'd1);
        rdreg(5'h04, rd); chk("R10 status running", {32'd0, rd}, 64'd0);
        ticks(100);
        chk("R3 100 ticks", count, 64'd100);
        repeat (5) @(negedge clk);
        chk("R3 idle hold", count, 64'd100);
        // R4 1/16 scale from 100: 160 ticks gives 110
        wr(5'h00, 0);
        rdreg(5'h04, rd); chk("R10 status halted", {32'd0, rd}, 64'd1);
        wr(5'h10, 32'h0010_0000);
        wr(5'h00, 32'd5);
        ticks(160);
        chk("R4 scaled 1/16", count, 64'd110);
        // R4/R5 vector table
        for (int v = 0; v < NVEC; v++) begin
            wr(5'h08, 0); wr(5'h0C, 0);
            wr(5'h10, V_SCALE[v]);
            ticks(V_TICKS[v]);
            chk($sformatf("R5 vector %0d", v), count, {32'd0, V_EXP[v]});
        end
        // R6 half writes
        wr(5'h00, 32'd0);
        wr(5'h08, 32'hDEAD_0001); wr(5'h0C, 32'h0000_0077);
        chk("R6 both halves", count, 64'h0000_0077_DEAD_0001);
        wr(5'h0C, 32'h0000_0011);
        chk("R6 high only", count, 64'h0000_0011_DEAD_0001);
        rdreg(5'h0C, rd); chk("R6 high read", {32'd0, rd}, 64'h11);
        // R9 carry across halves on one tick
        wr(5'h08, 32'hFFFF_FFFF); wr(5'h0C, 32'h5);
        wr(5'h00, 32'd1);
        ticks(1);
        chk("R9 carry", count, 64'h0000_0006_0000_0000);
        // R7 write and tick in same cycle
        @(negedge clk); addr = 5'h08; wdata = 32'h1234; we = 1; tick = 1;
        @(negedge clk); we = 0; tick = 0;
        chk("R7 write wins", count, 64'h0000_0006_0000_1234);
        // R8 scale write clears remainder
        wr(5'h08, 0); wr(5'h0C, 0);
        wr(5'h10, 32'h0080_0000); wr(5'h00, 32'd5);
        ticks(1);
        wr(5'h10, 32'h0080_0000);
        ticks(1);
        chk("R8 cleared by scale write", count, 64'd0);
        ticks(1);
        chk("R8 next tick", count, 64'd1);
        ticks(1);
        wr(5'h08, 32'd1);
        ticks(1);
        chk("R8 cleared by count write", count, 64'd1);
        // R11 unmapped address
        wr(5'h00, 32'd0);
        wr(5'h14, 32'hFFFF_FFFF);
        rdreg(5'h14, rd); chk("R11 read zero", {32'd0, rd}, 64'd0);
        rdreg(5'h00, rd); chk("R11 ctrl kept", {32'd0, rd}, 64'd0);
        rdreg(5'h10, rd); chk("R11 scale kept", {32'd0, rd}, 64'h0080_0000);
        chk("R11 count kept", count, 64'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule